// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Compare

This block is a 16-bit up/down timer for centre-aligned pulse-width modulation. The counter climbs from zero to a programmable ceiling, turns round, and falls back to zero, so every period is symmetric about its peak. The whole design runs on one system clock. The counter moves only on cycles where an enable tick from a selectable prescaler is present; the prescaler can be stopped or set to divide by 1, by 8 or by 64.

Software writes a compare value into a buffer. That value passes to the active compare register only at the tick where the counter sits at zero, so a new duty cycle always starts on a period boundary. When the counter equals the active compare value on a tick, the block sets a sticky match flag and updates the waveform pin. The action taken depends on a 2-bit output-mode field. A sticky overflow flag marks each visit to zero. A control bit can make the active compare value serve as the ceiling. With toggle mode selected as well, the pin then gives an exact 50% square wave.

All register writes use one synchronous port made up of `wr_en`, `wr_addr` and `wr_data`. The counter direction is held in a two-state machine. In state DIR_UP, a tick below the ceiling increments the counter. A tick at or above the ceiling takes the transition UP_TO_DOWN to DIR_DOWN and decrements. In state DIR_DOWN, a tick above zero decrements the counter. A tick at zero takes the transition DOWN_TO_UP to DIR_UP and moves the counter to 1.

Top module: `pfc_pwm_timer`

## Requirements
- R1: While `rst_n` is low, `count_o`, `cmp_o`, `match_flag_o`, `ovf_flag_o` and `wave_o` are all 0, and the direction state is DIR_UP.
- R2: The write address is 0 for the control register, and bits [1:0] of that register select the tick rate: 0 stops the counter (it holds its value and the prescaler is cleared), 1 ticks every clock, 2 ticks every 8th clock, and 3 ticks every 64th clock, each counted from the last tick or from leaving stop.
- R3: On each tick the counter steps by one toward the ceiling in DIR_UP and toward zero in DIR_DOWN. The ceiling value and zero each last exactly one tick, so after the ceiling value C comes C-1, and after 0 comes 1. With a ceiling of 0 the counter stays at 0.
- R4: When control bit 4 is 0, the ceiling is the value written to address 1. When control bit 4 is 1, the ceiling is the active compare value.
- R5: Writes to address 2 go to the compare buffer. The active compare value (`cmp_o`) copies the buffer only on a tick at which the counter is 0, and it changes at no other time.
- R6: A tick at which the counter equals the active compare value sets `match_flag_o` on the clock edge that ends that cycle. Writing address 4 with bit 0 set clears the flag, but a set in the same cycle wins.
- R7: A tick at which the counter is 0 sets `ovf_flag_o`. Writing address 4 with bit 1 set clears it, but a set in the same cycle wins.
- R8: Control bits [3:2] select the output mode. In mode 2 a match clears `wave_o` when in DIR_UP and sets it when in DIR_DOWN. Mode 3 does the reverse.
- R9: In mode 1 with control bit 4 set, each match toggles `wave_o`. In mode 1 with bit 4 clear, and in mode 0, `wave_o` is driven low.
- R10: A write to address 3 loads the counter at once. It cancels the tick events (match, overflow, compare copy and step) of its own cycle, and it suppresses the match on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 ceiling, 2 compare buffer, 3 counter, 4 flag clear) |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| cmp_o | output | 16 | Active compare value |
| match_flag_o | output | 1 | Sticky compare-match flag |
| ovf_flag_o | output | 1 | Sticky bottom (overflow) flag |
| wave_o | output | 1 | Waveform output |

## Verification
Every tick result appears one clock after the cycle that carries the tick: the counter step, both flags, the copy from buffer to active compare, and the pin update. A register write is captured at the same edge and affects behaviour from the following cycle. The bench steps a behavioural model on each rising edge from the same inputs the design sees, and compares all five outputs with it on the next falling edge, so every result is checked in the cycle it is due. Directed checks at the falling edge cover the stop hold, the ceiling source, pin toggling and the blocked match after a counter write.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        CS_STOP     = 2'd0,
        CS_DIV1     = 2'd1,
        CS_DIV_MID  = 2'd2,
        CS_DIV_HIGH = 2'd3
    } clk_sel_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLR_UP = 2'd2,
        OM_SET_UP = 2'd3
    } out_mode_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CEIL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CBUF = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FCLR = 3'd4;

endpackage

// File: rtl/pwm_tick_prescaler.sv
module pwm_tick_prescaler
    import pwm_timer_pkg::*;
#(
    parameter int DIV_MID  = 8,
    parameter int DIV_HIGH = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e sel,
    output logic     tick_o
);
    localparam int PW = $clog2(DIV_HIGH);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit  = (sel == CS_DIV_MID) ? PW'(DIV_MID - 1) : PW'(DIV_HIGH - 1);
        tick_o = 1'b0;
        unique case (sel)
            CS_STOP:     tick_o = 1'b0;
            CS_DIV1:     tick_o = 1'b1;
            CS_DIV_MID,
            CS_DIV_HIGH: tick_o = (pre_q >= limit);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (sel == CS_STOP || sel == CS_DIV1 || tick_o) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_MID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel == CS_DIV_MID) |=> (!tick_o || sel != CS_DIV_MID)); // R2

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] ceil,
    output logic [W-1:0] cnt_o,
    output dir_e         dir_o
);
    logic [W-1:0] cnt_q, cnt_d;
    dir_e         dir_q, dir_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    // next state
    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step) begin
            unique case (dir_q)
                DIR_UP: begin
                    if (cnt_q >= ceil) begin
                        dir_d = DIR_DOWN;
                        cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                DIR_DOWN: begin
                    if (cnt_q == '0) begin
                        dir_d = DIR_UP;
                        cnt_d = (ceil == '0) ? '0 : W'(1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign cnt_o = cnt_q;
    assign dir_o = dir_q;

    AST_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dir_q == DIR_UP && cnt_q == ceil && ceil != '0)
        |=> (cnt_q == $past(ceil) - 1'b1 && dir_q == DIR_DOWN)); // R3

    AST_FLOOR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dir_q == DIR_DOWN && cnt_q == '0 && ceil != '0)
        |=> (cnt_q == W'(1) && dir_q == DIR_UP)); // R3

endmodule

// File: rtl/pwm_compare_unit.sv
module pwm_compare_unit
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  dir_e         dir,
    input  logic         buf_wr,
    input  logic [W-1:0] buf_val,
    input  logic         cnt_wr,
    input  logic         clr_match,
    input  logic         clr_ovf,
    input  out_mode_e    omode,
    input  logic         ceil_from_cmp,
    output logic [W-1:0] cmp_o,
    output logic         match_flag_o,
    output logic         ovf_flag_o,
    output logic         wave_o
);
    logic [W-1:0] buf_q, act_q;
    logic         blk_q, mf_q, of_q, wave_q, wave_d;
    logic         at_floor, match_evt;

    assign at_floor  = step && (cnt == '0);
    assign match_evt = step && (cnt == act_q) && !blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            act_q  <= '0;
            blk_q  <= 1'b0;
            mf_q   <= 1'b0;
            of_q   <= 1'b0;
            wave_q <= 1'b0;
        end else begin
            if (buf_wr)   buf_q <= buf_val;
            if (at_floor) act_q <= buf_q;
            if (cnt_wr)    blk_q <= 1'b1;
            else if (step) blk_q <= 1'b0;
            if (match_evt)      mf_q <= 1'b1;
            else if (clr_match) mf_q <= 1'b0;
            if (at_floor)     of_q <= 1'b1;
            else if (clr_ovf) of_q <= 1'b0;
            wave_q <= wave_d;
        end
    end

    always_comb begin
        wave_d = wave_q;
        if (match_evt) begin
            unique case (omode)
                OM_OFF:    wave_d = wave_q;
                OM_TOGGLE: wave_d = ~wave_q;
                OM_CLR_UP: wave_d = (dir == DIR_DOWN);
                OM_SET_UP: wave_d = (dir == DIR_UP);
            endcase
        end
    end

    always_comb begin
        wave_o = 1'b0;
        unique case (omode)
            OM_OFF:    wave_o = 1'b0;
            OM_TOGGLE: wave_o = ceil_from_cmp ? wave_q : 1'b0;
            OM_CLR_UP,
            OM_SET_UP: wave_o = wave_q;
        endcase
    end

    assign cmp_o        = act_q;
    assign match_flag_o = mf_q;
    assign ovf_flag_o   = of_q;

    AST_CMP_ONLY_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && cnt == '0) |=> $stable(cmp_o)); // R5

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == cmp_o && !blk_q) |=> match_flag_o); // R6

    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == '0) |=> ovf_flag_o); // R7

    AST_BLOCKED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q && !match_flag_o && !cnt_wr) |=> !match_flag_o); // R10

endmodule

// File: rtl/pfc_pwm_timer.sv
module pfc_pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DIV_MID  = 8,
    parameter int DIV_HIGH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              match_flag_o,
    output logic              ovf_flag_o,
    output logic              wave_o
);
    clk_sel_e         sel_q;
    out_mode_e        omode_q;
    logic             ceil_src_q;
    logic [CNT_W-1:0] ceil_reg_q;
    logic [CNT_W-1:0] ceil_val;
    logic             tick, step;
    logic             ctrl_wr, ceil_wr, buf_wr, cnt_wr, fclr_wr;
    dir_e             dir;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign ceil_wr = wr_en && (wr_addr == A_CEIL);
    assign buf_wr  = wr_en && (wr_addr == A_CBUF);
    assign cnt_wr  = wr_en && (wr_addr == A_CNT);
    assign fclr_wr = wr_en && (wr_addr == A_FCLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= CS_STOP;
            omode_q    <= OM_OFF;
            ceil_src_q <= 1'b0;
            ceil_reg_q <= '0;
        end else begin
            if (ctrl_wr) begin
                sel_q      <= clk_sel_e'(wr_data[1:0]);
                omode_q    <= out_mode_e'(wr_data[3:2]);
                ceil_src_q <= wr_data[4];
            end
            if (ceil_wr) ceil_reg_q <= wr_data;
        end
    end

    pwm_tick_prescaler #(
        .DIV_MID  (DIV_MID),
        .DIV_HIGH (DIV_HIGH)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_q),
        .tick_o (tick)
    );

    assign step     = tick && !cnt_wr;
    assign ceil_val = ceil_src_q ? cmp_o : ceil_reg_q;

    pwm_updown_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (cnt_wr),
        .load_val (wr_data),
        .ceil     (ceil_val),
        .cnt_o    (count_o),
        .dir_o    (dir)
    );

    pwm_compare_unit #(.W(CNT_W)) u_cmp (
        .clk           (clk),
        .rst_n         (rst_n),
        .step          (step),
        .cnt           (count_o),
        .dir           (dir),
        .buf_wr        (buf_wr),
        .buf_val       (wr_data),
        .cnt_wr        (cnt_wr),
        .clr_match     (fclr_wr && wr_data[0]),
        .clr_ovf       (fclr_wr && wr_data[1]),
        .omode         (omode_q),
        .ceil_from_cmp (ceil_src_q),
        .cmp_o         (cmp_o),
        .match_flag_o  (match_flag_o),
        .ovf_flag_o    (ovf_flag_o),
        .wave_o        (wave_o)
    );

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == CS_STOP && !cnt_wr) |=> $stable(count_o)); // R2

    AST_CMP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (ceil_src_q && step && dir == DIR_UP && count_o == cmp_o && cmp_o != '0)
        |=> (count_o == $past(cmp_o) - 1'b1)); // R4

endmodule

// File: tb/sim_pfc_pwm_timer.sv
`timescale 1ns/1ps
module sim_pfc_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o, cmp_o;
    logic        match_flag_o, ovf_flag_o, wave_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfc_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .cmp_o(cmp_o), .match_flag_o(match_flag_o),
        .ovf_flag_o(ovf_flag_o), .wave_o(wave_o)
    );

    // behavioural reference model
    int m_pre, m_cnt, m_up, m_buf, m_act, m_ceil, m_sel, m_om, m_src;
    int m_blk, m_mf, m_of, m_wq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_up = 1; m_buf = 0; m_act = 0; m_ceil = 0;
            m_sel = 0; m_om = 0; m_src = 0; m_blk = 0; m_mf = 0; m_of = 0; m_wq = 0;
        end else begin
            int tk, lim, cw, st, c, mt, bt, nc, nu;
            cw = (wr_en && wr_addr == 3) ? 1 : 0;
            lim = (m_sel == 2) ? 7 : 63;
            if (m_sel == 0) tk = 0;
            else if (m_sel == 1) tk = 1;
            else tk = (m_pre >= lim) ? 1 : 0;
            if (m_sel <= 1 || tk) m_pre = 0; else m_pre = m_pre + 1;
            st = tk && !cw;
            c  = m_src ? m_act : m_ceil;
            mt = st && (m_cnt == m_act) && !m_blk;
            bt = st && (m_cnt == 0);
            if (mt) begin
                if (m_om == 1) m_wq = !m_wq;
                else if (m_om == 2) m_wq = m_up ? 0 : 1;
                else if (m_om == 3) m_wq = m_up ? 1 : 0;
            end
            nc = m_cnt; nu = m_up;
            if (cw) nc = wr_data;
            else if (st) begin
                if (m_up) begin
                    if (m_cnt >= c) begin nu = 0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin nu = 1; nc = (c == 0) ? 0 : 1; end
                    else nc = m_cnt - 1;
                end
            end
            if (mt) m_mf = 1; else if (wr_en && wr_addr == 4 && wr_data[0]) m_mf = 0;
            if (bt) m_of = 1; else if (wr_en && wr_addr == 4 && wr_data[1]) m_of = 0;
            if (bt) m_act = m_buf;
            if (cw) m_blk = 1; else if (st) m_blk = 0;
            if (wr_en && wr_addr == 2) m_buf = wr_data;
            if (wr_en && wr_addr == 1) m_ceil = wr_data;
            if (wr_en && wr_addr == 0) begin
                m_sel = wr_data[1:0]; m_om = wr_data[3:2]; m_src = wr_data[4];
            end
            m_cnt = nc; m_up = nu;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_wave();
        if (m_om == 0 || (m_om == 1 && m_src == 0)) return 0;
        return m_wq;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3", "count", int'(count_o), m_cnt);
            chk("R5", "cmp", int'(cmp_o), m_act);
            chk("R6", "match_flag", int'(match_flag_o), m_mf);
            chk("R7", "ovf_flag", int'(ovf_flag_o), m_of);
            chk("R8", "wave", int'(wave_o), exp_wave());
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        int held, mx, tog, lastw, zero_ok, v;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", int'({count_o, cmp_o, match_flag_o, ovf_flag_o, wave_o}), 0);
        #1 rst_n = 1'b1;

        // R3, R6, R7, R8: non-inverting, ceiling from register
        wr(1, 10); wr(2, 4); wr(0, (2 << 2) | 1);
        run(80);
        wr(2, 7);            // R5: buffered change
        run(60);
        wr(4, 3);
        run(5);
        wr(0, (3 << 2) | 1); // R8 inverted form
        run(60);

        // R2: stop holds the counter
        wr(0, (3 << 2) | 0);
        @(negedge clk); held = count_o;
        zero_ok = 1;
        repeat (40) begin @(negedge clk); if (count_o != 16'(held)) zero_ok = 0; end
        chk("R2", "stopped counter stable", zero_ok, 1);

        // R2: divide by 8 and by 64
        wr(0, (3 << 2) | 2);
        run(400);
        wr(0, (2 << 2) | 3);
        run(1500);

        // R4, R9: compare defines ceiling, toggle mode
        wr(2, 5); wr(0, 16 | (1 << 2) | 1);
        run(40);
        mx = 0; tog = 0; lastw = wave_o;
        repeat (200) begin
            @(negedge clk);
            if (count_o > 16'(mx)) mx = count_o;
            if (int'(wave_o) != lastw) tog++;
            lastw = wave_o;
        end
        chk("R4", "peak equals active compare", mx, int'(cmp_o));
        chk("R9", "toggle count >= 4", (tog >= 4) ? 1 : 0, 1);

        // R9: mode 0 drives low
        wr(0, 16 | 1);
        zero_ok = 1;
        repeat (30) begin @(negedge clk); if (wave_o) zero_ok = 0; end
        chk("R9", "mode 0 low", zero_ok, 1);

        // R10: counter write blocks the next match
        wr(0, 16 | (2 << 2));
        wr(4, 3);
        v = cmp_o;
        wr(3, v);
        chk("R10", "count loaded", int'(count_o), v);
        wr(0, 16 | (2 << 2) | 1);
        @(negedge clk);
        chk("R10", "match blocked", int'(match_flag_o), 0);
        run(20);

        finish_up();
    end
endmodule